// File: doc/BRIEF.md
# Programmable Address Window Decoder with Translation

This block holds a bank of software-programmed address windows. Each window claims a power-of-two region of a 36-bit bus address space and names the device behind that region by a 4-bit target code and an 8-bit attribute code. When a request address is presented, every window compares it in parallel. The lowest-numbered matching window supplies the target, the attribute and the outgoing address. If no window matches, the block raises a decode error.

Windows come in two kinds, chosen by a parameter. Windows with an index below `NUM_REMAP` carry translation registers and replace the high part of the address. All other windows pass the address through unchanged. Software programs the windows through a simple word-wide register port. The register layout is uneven: each of the first eight windows has a four-word slot, and the remaining windows have two-word slots placed after a reserved gap.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads 0, and every request misses.
- R2: The control word holds: enable in bit 0, the target code in bits 7:4, the attribute code in bits 15:8, and the window size in 64 KiB units minus one in bits 31:16. A hit reports this window's target and attribute.
- R3: The base word holds address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. Its other bits read 0. A hit requires bits 35:32 of the address to equal the stored high nibble.
- R4: An enabled window hits when address bits 31:16 equal the base bits 31:16 in every position where the size field holds 0. An address one byte past the end of the region misses.
- R5: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R6: When several windows hit, the lowest index wins and the multi-hit flag is raised. When exactly one window hits, the flag stays low.
- R7: On a miss the decode-error flag is set. The target, attribute and window index are 0, and the outgoing address equals the request address.
- R8: A hit in a translating window (index below `NUM_REMAP`) produces an outgoing address built as follows:
  - bits 35:32 come from the low nibble of its remap-high word;
  - bits 31:16 are `(remapLo[31:16] & ~size) | (addr[31:16] & size)`;
  - bits 15:0 are unchanged.
  The remap-low word holds bits 31:16; its other bits read 0.
- R9: A hit in a window with index at or above `NUM_REMAP` passes the address through unchanged.
- R10: For windows at or above `NUM_REMAP`, the remap-low and remap-high words read 0 and writes to them are ignored.
- R11: Register byte offsets are as follows:
  - Window w below 8: control at `w*0x10`, base at `+4`, remap-low at `+8`, remap-high at `+0xC`.
  - Window w at 8 or above: control at `0x90+(w-8)*8`, base at `+4`.
  - Offsets 0x80–0x8F, and offsets past the last window, read 0 and ignore writes.
- R12: Timing follows registered edges:
  - Decode results appear one cycle after `req_valid`.
  - Read data appears one cycle after `reg_re` and is held until the next read.
  - A write changes decodes only from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| req_valid | input | 1 | Decode request valid |
| req_addr | input | ADDR_W | Request bus address |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | Some enabled window matched |
| dec_miss | output | 1 | Decode error: no window matched |
| dec_multi | output | 1 | More than one window matched |
| dec_win | output | WIN_W | Index of the winning window |
| dec_target | output | 4 | Target code of the winning window |
| dec_attr | output | 8 | Attribute code of the winning window |
| dec_addr | output | ADDR_W | Outgoing (translated or passed) address |

## Verification
Every decode output is registered once, so a request driven in one cycle shows its result after exactly one rising edge. A read returns data after exactly one edge. A write affects decoding only for requests issued after that write's edge.

The bench drives inputs on the falling edge and samples on the next falling edge. This places each check one edge after its stimulus. One scenario issues a write and a request in the same cycle and confirms that the request still sees the old setting.

A second instance with fewer translating windows receives the same stimulus. Through it, the bench observes the ignored remap writes, both at the read port and at the outgoing address.

// File: rtl/awd_pkg.sv
package awd_pkg;
  // Word selector inside one window's register slot.
  typedef enum logic [1:0] {
    WORD_CTRL = 2'd0,
    WORD_BASE = 2'd1,
    WORD_RLO  = 2'd2,
    WORD_RHI  = 2'd3
  } awd_word_e;

  localparam int GRAN_SHIFT = 16;  // 64 KiB granule
  localparam int TGT_W      = 4;
  localparam int ATTR_W     = 8;
endpackage

// File: rtl/awd_reg_map.sv
// Translates a register byte offset into (window, word), honouring the
// four-word low slots, the reserved gap and the two-word high slots.
module awd_reg_map
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20,
  parameter int LOW_WIN = 8,
  parameter int REG_AW  = 8,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input  logic [REG_AW-1:0] off,
  output logic              map_valid,
  output logic [WIN_W-1:0]  map_win,
  output awd_word_e         map_word
);
  localparam logic [REG_AW:0] LOW_END    = (REG_AW+1)'(LOW_WIN * 16);
  localparam logic [REG_AW:0] HIGH_START = (REG_AW+1)'(LOW_WIN * 16 + 16);
  localparam logic [REG_AW:0] HIGH_END   = (REG_AW+1)'(LOW_WIN * 16 + 16 + (NUM_WIN - LOW_WIN) * 8);

  logic [REG_AW:0] off_x;
  logic [REG_AW:0] high_rel;

  assign off_x    = {1'b0, off};
  assign high_rel = off_x - HIGH_START;

  always_comb begin
    map_valid = 1'b0;
    map_win   = '0;
    map_word  = WORD_CTRL;
    if (off_x < LOW_END) begin
      map_valid = 1'b1;
      map_win   = WIN_W'(off_x >> 4);
      map_word  = awd_word_e'(off[3:2]);
    end else if (off_x >= HIGH_START && off_x < HIGH_END) begin
      map_valid = 1'b1;
      map_win   = WIN_W'(LOW_WIN) + WIN_W'(high_rel >> 3);
      map_word  = awd_word_e'({1'b0, high_rel[2]});
    end
  end
endmodule

// File: rtl/awd_window.sv
// One address window: its registers, its match test and its outgoing address.
module awd_window
  import awd_pkg::*;
#(
  parameter int  HI_W  = 4,
  parameter bit  REMAP = 1'b1,
  localparam int ADDR_W = 32 + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  awd_word_e         wr_word,
  input  logic [31:0]       wr_data,
  input  awd_word_e         rd_word,
  output logic [31:0]       rd_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [TGT_W-1:0]  target,
  output logic [ATTR_W-1:0] attr,
  output logic [ADDR_W-1:0] xlat_addr
);
  logic [31:0]     ctrl_q;
  logic [15:0]     base_lo_q;
  logic [HI_W-1:0] base_hi_q;
  logic [15:0]     rlo_q;
  logic [HI_W-1:0] rhi_q;
  logic [15:0]     size_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        WORD_CTRL: ctrl_q <= wr_data;
        WORD_BASE: begin
          base_lo_q <= wr_data[31:16];
          base_hi_q <= wr_data[HI_W-1:0];
        end
        default: ;
      endcase
    end
  end

  generate
    if (REMAP) begin : g_remap
      always_ff @(posedge clk) begin
        if (rst) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (wr_en && wr_word == WORD_RLO) begin
          rlo_q <= wr_data[31:16];
        end else if (wr_en && wr_word == WORD_RHI) begin
          rhi_q <= wr_data[HI_W-1:0];
        end
      end
    end else begin : g_plain
      assign rlo_q = '0;
      assign rhi_q = '0;
    end
  endgenerate

  assign size_mask = ctrl_q[31:16];
  assign target    = ctrl_q[7:4];
  assign attr      = ctrl_q[15:8];
  assign hit       = ctrl_q[0]
                   && (((look_addr[31:16] ^ base_lo_q) & ~size_mask) == 16'h0)
                   && (look_addr[ADDR_W-1:32] == base_hi_q);

  generate
    if (REMAP) begin : g_xlat
      assign xlat_addr = {rhi_q, (rlo_q & ~size_mask) | (look_addr[31:16] & size_mask),
                          look_addr[15:0]};
    end else begin : g_pass
      assign xlat_addr = look_addr;
    end
  endgenerate

  always_comb begin
    case (rd_word)
      WORD_CTRL: rd_data = ctrl_q;
      WORD_BASE: rd_data = {base_lo_q, {(16-HI_W){1'b0}}, base_hi_q};
      WORD_RLO:  rd_data = {rlo_q, 16'h0};
      default:   rd_data = {{(32-HI_W){1'b0}}, rhi_q};
    endcase
  end
endmodule

// File: rtl/awd_select.sv
// Lowest-index priority among matching windows, plus multi-match detection.
module awd_select #(
  parameter int  NUM_WIN = 20,
  localparam int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_WIN-1:0] hits,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [WIN_W-1:0]   win_idx,
  output logic [NUM_WIN-1:0] grant
);
  always_comb begin
    win_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) win_idx = WIN_W'(i);
    end
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hits[i] && ((hits & ((NUM_WIN)'(1) << i) - 1'b1) == '0) == 1'b1) grant[i] = 1'b1;
    end
  end

  assign any_hit   = |hits;
  assign multi_hit = (hits & (hits - 1'b1)) != '0;

  // R6: at most one window is granted, and only a matching one
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  a_r6_grant_in_hits: assert property (@(posedge clk) disable iff (rst)
    (grant & ~hits) == '0);
  a_r6_grant_when_any: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (grant != '0));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int  NUM_WIN   = 20,
  parameter int  NUM_REMAP = 8,
  parameter int  LOW_WIN   = 8,
  parameter int  HI_W      = 4,
  parameter int  REG_AW    = 8,
  localparam int WIN_W     = $clog2(NUM_WIN),
  localparam int ADDR_W    = 32 + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_miss,
  output logic              dec_multi,
  output logic [WIN_W-1:0]  dec_win,
  output logic [TGT_W-1:0]  dec_target,
  output logic [ATTR_W-1:0] dec_attr,
  output logic [ADDR_W-1:0] dec_addr
);
  localparam logic [WIN_W-1:0] REMAP_LIM = WIN_W'(NUM_REMAP);

  logic              map_valid;
  logic [WIN_W-1:0]  map_win;
  awd_word_e         map_word;

  logic [31:0]       rd_arr   [NUM_WIN];
  logic [TGT_W-1:0]  tgt_arr  [NUM_WIN];
  logic [ATTR_W-1:0] attr_arr [NUM_WIN];
  logic [ADDR_W-1:0] xlat_arr [NUM_WIN];
  logic [NUM_WIN-1:0] hits;
  logic [NUM_WIN-1:0] grant;
  logic              any_hit;
  logic              multi_hit;
  logic [WIN_W-1:0]  win_idx;

  awd_reg_map #(.NUM_WIN(NUM_WIN), .LOW_WIN(LOW_WIN), .REG_AW(REG_AW)) u_map (
    .off(reg_addr), .map_valid(map_valid), .map_win(map_win), .map_word(map_word)
  );

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      awd_window #(.HI_W(HI_W), .REMAP(w < NUM_REMAP)) u_win (
        .clk(clk),
        .rst(rst),
        .wr_en(reg_we && map_valid && (map_win == WIN_W'(w))),
        .wr_word(map_word),
        .wr_data(reg_wdata),
        .rd_word(map_word),
        .rd_data(rd_arr[w]),
        .look_addr(req_addr),
        .hit(hits[w]),
        .target(tgt_arr[w]),
        .attr(attr_arr[w]),
        .xlat_addr(xlat_arr[w])
      );
    end
  endgenerate

  awd_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk(clk), .rst(rst), .hits(hits), .any_hit(any_hit),
    .multi_hit(multi_hit), .win_idx(win_idx), .grant(grant)
  );

  // Register read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      reg_rdata <= map_valid ? rd_arr[map_win] : 32'h0;
    end
  end

  // Registered decode result
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_hit    <= 1'b0;
      dec_miss   <= 1'b0;
      dec_multi  <= 1'b0;
      dec_win    <= '0;
      dec_target <= '0;
      dec_attr   <= '0;
      dec_addr   <= '0;
    end else begin
      dec_valid  <= req_valid;
      dec_hit    <= req_valid && any_hit;
      dec_miss   <= req_valid && !any_hit;
      dec_multi  <= req_valid && multi_hit;
      dec_win    <= any_hit ? win_idx : '0;
      dec_target <= any_hit ? tgt_arr[win_idx] : '0;
      dec_attr   <= any_hit ? attr_arr[win_idx] : '0;
      dec_addr   <= any_hit ? xlat_arr[win_idx] : req_addr;
    end
  end

  // R12: one-cycle decode latency
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  // R7: hit and decode error never together
  a_r7_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    !(dec_hit && dec_miss));
  // R7: a miss reports null target and attribute
  a_r7_miss_null: assert property (@(posedge clk) disable iff (rst)
    dec_miss |-> (dec_target == '0 && dec_attr == '0 && dec_win == '0));
  // R6: multi-hit implies a hit
  a_r6_multi_hit: assert property (@(posedge clk) disable iff (rst)
    dec_multi |-> dec_hit);
  // R9: non-translating winners pass the address through
  a_r9_passthrough: assert property (@(posedge clk) disable iff (rst)
    (req_valid && any_hit && win_idx >= REMAP_LIM) |=> dec_addr == $past(req_addr));
  // R11: unmapped offsets read as zero
  a_r11_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !map_valid) |=> reg_rdata == 32'h0);
endmodule

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;

  logic [31:0] rdata_a, rdata_b;
  logic        v_a, hit_a, miss_a, multi_a, v_b, hit_b, miss_b, multi_b;
  logic [4:0]  win_a, win_b;
  logic [3:0]  tgt_a, tgt_b;
  logic [7:0]  attr_a, attr_b;
  logic [35:0] addr_a, addr_b;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .req_valid(req_valid), .req_addr(req_addr),
    .dec_valid(v_a), .dec_hit(hit_a), .dec_miss(miss_a), .dec_multi(multi_a),
    .dec_win(win_a), .dec_target(tgt_a), .dec_attr(attr_a), .dec_addr(addr_a)
  );

  // Same stimulus, only four translating windows
  addr_window_decoder #(.NUM_REMAP(4)) uut_r4 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .req_valid(req_valid), .req_addr(req_addr),
    .dec_valid(v_b), .dec_hit(hit_b), .dec_miss(miss_b), .dec_multi(multi_b),
    .dec_win(win_b), .dec_target(tgt_b), .dec_attr(attr_b), .dec_addr(addr_b)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = off;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic dec(input logic [35:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_dec(input string tag, input logic hit, input logic multi,
                         input logic [4:0] win, input logic [3:0] tgt,
                         input logic [7:0] attr, input logic [35:0] addr);
    chk({tag, " valid"}, 64'(v_a), 64'd1);
    chk({tag, " hit"},   64'(hit_a), 64'(hit));
    chk({tag, " miss"},  64'(miss_a), 64'(!hit));
    chk({tag, " multi"}, 64'(multi_a), 64'(multi));
    chk({tag, " win"},   64'(win_a), 64'(win));
    chk({tag, " target"},64'(tgt_a), 64'(tgt));
    chk({tag, " attr"},  64'(attr_a), 64'(attr));
    chk({tag, " addr"},  64'(addr_a), 64'(addr));
  endtask

  task automatic t_reset;
    rd(8'h00); chk("R1 ctrl w0 after reset", 64'(rdata_a), 64'h0);
    rd(8'h04); chk("R1 base w0 after reset", 64'(rdata_a), 64'h0);
    dec(36'h0_1234_5678);
    chk_dec("R1 decode after reset", 1'b0, 1'b0, 5'd0, 4'd0, 8'd0, 36'h0_1234_5678);
  endtask

  task automatic t_layout;
    wr(8'h9C, 32'hFFFF_FFFF);           // window 9 base
    rd(8'h9C); chk("R3 R11 base w9 implemented bits", 64'(rdata_a), 64'hFFFF_000F);
    wr(8'h0C, 32'hFFFF_FFFF);           // window 0 remap-high
    rd(8'h0C); chk("R11 remap-high w0", 64'(rdata_a), 64'h0000_000F);
    wr(8'h84, 32'hDEAD_BEEF);           // reserved gap
    rd(8'h84); chk("R11 gap reads zero", 64'(rdata_a), 64'h0);
    rd(8'h74); chk("R11 gap write left w7 base", 64'(rdata_a), 64'h0);
    rd(8'h90); chk("R11 gap write left w8 ctrl", 64'(rdata_a), 64'h0);
    wr(8'hF0, 32'h1234_5678);           // past last window
    rd(8'hF0); chk("R11 past end reads zero", 64'(rdata_a), 64'h0);
  endtask

  task automatic t_translate;
    wr(8'h04, 32'h1000_0000);
    wr(8'h08, 32'h8000_FFFF);
    wr(8'h0C, 32'h0000_0002);
    wr(8'h00, 32'h000F_3C21);           // 1 MiB, attr 3C, target 2, on
    rd(8'h00); chk("R2 ctrl w0 readback", 64'(rdata_a), 64'h000F_3C21);
    rd(8'h08); chk("R8 remap-low w0 readback", 64'(rdata_a), 64'h8000_0000);
    dec(36'h0_1003_4567);
    chk_dec("R2 R8 translate w0", 1'b1, 1'b0, 5'd0, 4'h2, 8'h3C, 36'h2_8003_4567);
    dec(36'h0_100F_FFFF);
    chk_dec("R4 last byte w0", 1'b1, 1'b0, 5'd0, 4'h2, 8'h3C, 36'h2_800F_FFFF);
    dec(36'h0_1010_0000);
    chk_dec("R4 one past end w0", 1'b0, 1'b0, 5'd0, 4'h0, 8'h0, 36'h0_1010_0000);
    dec(36'h1_1003_4567);
    chk_dec("R3 high nibble mismatch", 1'b0, 1'b0, 5'd0, 4'h0, 8'h0, 36'h1_1003_4567);
  endtask

  task automatic t_passthrough;
    wr(8'h9C, 32'h2000_0001);
    wr(8'h98, 32'h0000_A5E1);           // 64 KiB, attr A5, target E
    dec(36'h1_2000_ABCD);
    chk_dec("R9 passthrough w9", 1'b1, 1'b0, 5'd9, 4'hE, 8'hA5, 36'h1_2000_ABCD);
    dec(36'h1_2001_0000);
    chk_dec("R4 past 64K w9", 1'b0, 1'b0, 5'd0, 4'h0, 8'h0, 36'h1_2001_0000);
  endtask

  task automatic t_priority;
    wr(8'h34, 32'h1000_0000);
    wr(8'h30, 32'h00FF_0751);           // 16 MiB, attr 07, target 5
    dec(36'h0_1003_4567);
    chk_dec("R6 overlap lowest wins", 1'b1, 1'b1, 5'd0, 4'h2, 8'h3C, 36'h2_8003_4567);
    dec(36'h0_1080_0000);
    chk_dec("R6 R8 single hit w3", 1'b1, 1'b0, 5'd3, 4'h5, 8'h07, 36'h0_0080_0000);
  endtask

  task automatic t_disable;
    wr(8'h00, 32'h000F_3C20);
    dec(36'h0_1003_4567);
    chk_dec("R5 disabled w0 skipped", 1'b1, 1'b0, 5'd3, 4'h5, 8'h07, 36'h0_0003_4567);
  endtask

  task automatic t_remap_limit;
    wr(8'h54, 32'h3000_0000);
    wr(8'h58, 32'h4000_0000);
    wr(8'h50, 32'h0000_1161);
    rd(8'h58);
    chk("R8 remap-low w5 translating", 64'(rdata_a), 64'h4000_0000);
    chk("R10 remap-low w5 plain reads zero", 64'(rdata_b), 64'h0);
    dec(36'h0_3000_1234);
    chk_dec("R8 translate w5", 1'b1, 1'b0, 5'd5, 4'h6, 8'h11, 36'h0_4000_1234);
    chk("R10 plain w5 hit", 64'(hit_b), 64'd1);
    chk("R10 plain w5 address unchanged", 64'(addr_b), 64'h0_3000_1234);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h98; reg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 36'h1_2000_ABCD;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    chk_dec("R12 same-cycle write unseen", 1'b1, 1'b0, 5'd9, 4'hE, 8'hA5, 36'h1_2000_ABCD);
    dec(36'h1_2000_ABCD);
    chk_dec("R12 write seen next cycle", 1'b0, 1'b0, 5'd0, 4'h0, 8'h0, 36'h1_2000_ABCD);
    rd(8'h98); chk("R12 read data after disable", 64'(rdata_a), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_translate();
    t_passthrough();
    t_priority();
    t_disable();
    t_remap_limit();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule